// File: doc/BRIEF.md
# Dual-Device NOR Flash Command Sequencer

This block runs the write and status-poll command sequences for a 32-bit flash array. The array is two 16-bit devices wired side by side, so every command code goes out on both halves of the bus at the same time. On a one-cycle request, the block carries out one of three operations and reports the outcome with a done pulse and an error flag. It can identify the part, erase one block, or program one 32-bit word.

Erase and program each start with a pair of writes. The block then polls the status register until both devices report ready, or until a poll limit runs out. It checks the error bit that belongs to the operation and puts the devices back into array-read mode. A program operation then reads the word back and compares it with the data that was written. Identify switches the devices into identifier mode, reads two identifier words, returns them to array mode, and accepts only the expected manufacturer and device codes.

The flash side is a simple synchronous bus. Each access is one cycle with either a write strobe or a read strobe. Read data arrives on the cycle after the read strobe.

Top module: `flash_cmd_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle: busy, done, err, flWe and flRe are all low.
- R2: A command write places the 8-bit code in bits 7:0 and 23:16 and zeros in bits 15:8 and 31:24. The codes are array read 0xFF, identify 0x90, status read 0x70, erase setup 0x20, erase confirm 0xD0 and program setup 0x40.
- R3: Identify (reqOp 0) writes 0x00900090 to word 0, reads word 0 and then word 1, and writes 0x00FF00FF to word 0. err is low only if word 0 read 0x00890089 and word 1 read 0x88F388F3 or 0x88F488F4.
- R4: Erase (reqOp 1) writes 0x00200020 and then 0x00D000D0 to reqAddr.
- R5: Program (reqOp 2) writes 0x00400040 to reqAddr and then writes reqData to reqAddr.
- R6: Polling repeats two steps: write 0x00700070, then read the same address. Status is taken from the read data one cycle after the read strobe. Polling stops only when bits 7 and 23 are both set.
- R7: When polling ends, the block writes 0x00FF00FF to the target address. An erase fails if bit 5 or bit 21 of the final status is set. A program fails if bit 4 or bit 20 is set. Each operation ignores the other operation's error bits.
- R8: After a program, the block reads the target word in array mode. err is raised if that word differs from reqData.
- R9: If MAX_POLLS status reads all show not-ready, the block stops polling, writes the array-read command, and finishes with err high.
- R10: busy goes high in the cycle after a request is accepted and stays high through the done cycle. done is a single-cycle pulse, and err is valid during it. flWe and flRe are never high together.
- R11: A request made while busy is ignored. A request with reqOp 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Operation request, one cycle |
| reqOp | input | 2 | 0 identify, 1 erase, 2 program, 3 ignored |
| reqAddr | input | AW | Target word address |
| reqData | input | 32 | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (pulse) |
| err | output | 1 | Outcome of the finished operation, valid with done |
| flAddr | output | AW | Flash word address |
| flWdata | output | 32 | Flash write data |
| flRdata | input | 32 | Flash read data, valid one cycle after flRe |
| flWe | output | 1 | Flash write strobe |
| flRe | output | 1 | Flash read strobe |

## Verification
A wrong sequencer state shows up on the flash bus within a few cycles. It can appear as a command word out of order, a read without a preceding status-read command, or a missing array-read write before done. A bus-side device model logs every write and counts status and array reads, so the exact number of poll rounds is visible. A single-half ready status and a never-ready status separate a correct ready test and poll limit from wrong ones. Error-bit injection and a corrupting write mask show whether each operation tests its own error bit and whether the read-back comparison is done.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_IDENT = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    AD_TGT,
    AD_W0,
    AD_W1
  } addr_sel_e;

  typedef enum logic [2:0] {
    WS_ARRAY,
    WS_IDENT,
    WS_STAT,
    WS_ERASE,
    WS_CONFIRM,
    WS_PROG,
    WS_DATA
  } wsel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    logic      we;
    logic      re;
    addr_sel_e addrSel;
    wsel_e     wSel;
  } ctl_s;

  // decoded read-data flags from datapath to control
  typedef struct packed {
    logic ready;
    logic eraseErr;
    logic pgmErr;
    logic mfrOk;
    logic devOk;
    logic verifyOk;
  } flag_s;

  localparam logic [7:0] CODE_ARRAY   = 8'hFF;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_STAT    = 8'h70;
  localparam logic [7:0] CODE_ERASE   = 8'h20;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_PROG    = 8'h40;

  localparam logic [31:0] ST_READY     = 32'h0080_0080;
  localparam logic [31:0] ST_ERASE_ERR = 32'h0020_0020;
  localparam logic [31:0] ST_PGM_ERR   = 32'h0010_0010;
  localparam logic [31:0] ID_MFR       = 32'h0089_0089;
  localparam logic [31:0] ID_DEV_A     = 32'h88F3_88F3;
  localparam logic [31:0] ID_DEV_B     = 32'h88F4_88F4;

  function automatic logic [31:0] dupCode(input logic [7:0] code);
    return {8'h00, code, 8'h00, code};
  endfunction

endpackage

// File: rtl/flash_seq_dp.sv
`timescale 1ns/1ps
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_s          ctl,
  input  logic [AW-1:0] reqAddr,
  input  logic [31:0]   reqData,
  input  logic [31:0]   flRdata,
  output logic [AW-1:0] flAddr,
  output logic [31:0]   flWdata,
  output flag_s         flags
);

  logic [AW-1:0] tgtAddr;
  logic [31:0]   tgtData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtAddr <= '0;
      tgtData <= '0;
    end else if (ctl.load) begin
      tgtAddr <= reqAddr;
      tgtData <= reqData;
    end
  end

  always_comb begin
    unique case (ctl.addrSel)
      AD_W0:   flAddr = '0;
      AD_W1:   flAddr = AW'(1);
      default: flAddr = tgtAddr;
    endcase
  end

  always_comb begin
    unique case (ctl.wSel)
      WS_IDENT:   flWdata = dupCode(CODE_IDENT);
      WS_STAT:    flWdata = dupCode(CODE_STAT);
      WS_ERASE:   flWdata = dupCode(CODE_ERASE);
      WS_CONFIRM: flWdata = dupCode(CODE_CONFIRM);
      WS_PROG:    flWdata = dupCode(CODE_PROG);
      WS_DATA:    flWdata = tgtData;
      default:    flWdata = dupCode(CODE_ARRAY);
    endcase
  end

  always_comb begin
    flags.ready    = (flRdata & ST_READY) == ST_READY;
    flags.eraseErr = |(flRdata & ST_ERASE_ERR);
    flags.pgmErr   = |(flRdata & ST_PGM_ERR);
    flags.mfrOk    = flRdata == ID_MFR;
    flags.devOk    = (flRdata == ID_DEV_A) || (flRdata == ID_DEV_B);
    flags.verifyOk = flRdata == tgtData;
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
`timescale 1ns/1ps
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int MAX_POLLS = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  flag_s      flags,
  output ctl_s       ctl,
  output logic       busy,
  output logic       done,
  output logic       err
);

  localparam int PCW = $clog2(MAX_POLLS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ARG, S_PCMD, S_PRD, S_PCAP, S_ARRAY,
    S_VRD, S_VCAP, S_IRD0, S_ICAP0, S_IRD1, S_ICAP1, S_DONE
  } state_e;

  state_e         state, nextState;
  op_e            opReg;
  logic           errReg, errNext;
  logic [PCW-1:0] pollCnt, pollNext;
  logic           accept;

  assign accept = (state == S_IDLE) && reqValid && (reqOp != 2'd3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opReg   <= OP_IDENT;
      errReg  <= 1'b0;
      pollCnt <= '0;
    end else begin
      state   <= nextState;
      errReg  <= errNext;
      pollCnt <= pollNext;
      if (accept) opReg <= op_e'(reqOp);
    end
  end

  always_comb begin
    nextState = state;
    errNext   = errReg;
    pollNext  = pollCnt;
    unique case (state)
      S_IDLE: if (accept) begin
        nextState = S_SETUP;
        errNext   = 1'b0;
        pollNext  = '0;
      end
      S_SETUP: nextState = (opReg == OP_IDENT) ? S_IRD0 : S_ARG;
      S_ARG:   nextState = S_PCMD;
      S_PCMD:  nextState = S_PRD;
      S_PRD:   nextState = S_PCAP;
      S_PCAP: begin
        if (flags.ready) begin
          nextState = S_ARRAY;
          errNext   = errReg | ((opReg == OP_ERASE) ? flags.eraseErr : flags.pgmErr);
        end else if (pollCnt == PCW'(MAX_POLLS - 1)) begin
          nextState = S_ARRAY;
          errNext   = 1'b1;
        end else begin
          nextState = S_PCMD;
          pollNext  = pollCnt + 1'b1;
        end
      end
      S_ARRAY: nextState = (opReg == OP_PROG) ? S_VRD : S_DONE;
      S_VRD:   nextState = S_VCAP;
      S_VCAP: begin
        nextState = S_DONE;
        errNext   = errReg | !flags.verifyOk;
      end
      S_IRD0:  nextState = S_ICAP0;
      S_ICAP0: begin
        nextState = S_IRD1;
        errNext   = errReg | !flags.mfrOk;
      end
      S_IRD1:  nextState = S_ICAP1;
      S_ICAP1: begin
        nextState = S_ARRAY;
        errNext   = errReg | !flags.devOk;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = accept;
    ctl.addrSel = AD_TGT;
    ctl.wSel    = WS_ARRAY;
    unique case (state)
      S_SETUP: begin
        ctl.we      = 1'b1;
        ctl.addrSel = (opReg == OP_IDENT) ? AD_W0 : AD_TGT;
        ctl.wSel    = (opReg == OP_IDENT) ? WS_IDENT :
                      (opReg == OP_ERASE) ? WS_ERASE : WS_PROG;
      end
      S_ARG: begin
        ctl.we   = 1'b1;
        ctl.wSel = (opReg == OP_ERASE) ? WS_CONFIRM : WS_DATA;
      end
      S_PCMD: begin
        ctl.we   = 1'b1;
        ctl.wSel = WS_STAT;
      end
      S_ARRAY: begin
        ctl.we      = 1'b1;
        ctl.addrSel = (opReg == OP_IDENT) ? AD_W0 : AD_TGT;
      end
      S_PRD, S_VRD: ctl.re = 1'b1;
      S_IRD0: begin
        ctl.re      = 1'b1;
        ctl.addrSel = AD_W0;
      end
      S_IRD1: begin
        ctl.re      = 1'b1;
        ctl.addrSel = AD_W1;
      end
      default: ;
    endcase
  end

  assign busy = state != S_IDLE;
  assign done = state == S_DONE;
  assign err  = done & errReg;

endmodule

// File: rtl/flash_cmd_sequencer.sv
`timescale 1ns/1ps
module flash_cmd_sequencer
  import flash_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [31:0]   reqData,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] flAddr,
  output logic [31:0]   flWdata,
  input  logic [31:0]   flRdata,
  output logic          flWe,
  output logic          flRe
);

  ctl_s  ctl;
  flag_s flags;
  logic  dataPhase;

  flash_seq_ctrl #(.MAX_POLLS(MAX_POLLS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .flags    (flags),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .err      (err)
  );

  flash_seq_dp #(.AW(AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .flRdata (flRdata),
    .flAddr  (flAddr),
    .flWdata (flWdata),
    .flags   (flags)
  );

  assign flWe      = ctl.we;
  assign flRe      = ctl.re;
  assign dataPhase = ctl.wSel == WS_DATA;

endmodule

// File: rtl/flash_cmd_sequencer_chk.sv
`timescale 1ns/1ps
module flash_cmd_sequencer_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          done,
  input logic          flWe,
  input logic          flRe,
  input logic [AW-1:0] flAddr,
  input logic [31:0]   flWdata,
  input logic          dataPhase
);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (!busy && !done && !flWe && !flRe)
        else $error("R1 outputs active during reset");
    end
  end

  assert_cmd_dup_R2: assert property (@(posedge clk) disable iff (!rstN)
    (flWe && !dataPhase) |->
      (flWdata[31:16] == flWdata[15:0]) && (flWdata[15:8] == 8'h00))
    else $error("R2 command word not replicated");

  assert_poll_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flWe && !dataPhase && flWdata == 32'h0070_0070) |=>
      (flRe && flAddr == $past(flAddr)))
    else $error("R6 status command not followed by status read");

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(flWe && flRe))
    else $error("R10 both strobes high");

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done)
    else $error("R10 done longer than one cycle");

  assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy)
    else $error("R10 done without busy");

endmodule

bind flash_cmd_sequencer flash_cmd_sequencer_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .flWe      (flWe),
  .flRe      (flRe),
  .flAddr    (flAddr),
  .flWdata   (flWdata),
  .dataPhase (dataPhase)
);

// File: tb/flash_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module flash_cmd_sequencer_tb;

  localparam int AW = 8;
  localparam int MAXP = 16;
  localparam logic [31:0] ARR_CMD = 32'h00FF_00FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic busy, done, err, flWe, flRe;
  logic [AW-1:0] flAddr;
  logic [31:0] flWdata;
  logic [31:0] flRdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  flash_cmd_sequencer #(.AW(AW), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .err(err), .flAddr(flAddr), .flWdata(flWdata), .flRdata(flRdata),
    .flWe(flWe), .flRe(flRe)
  );

  // device model configuration (driven by the test tasks only)
  logic [31:0] cfgMfr = 32'h0089_0089;
  logic [31:0] cfgDev = 32'h88F3_88F3;
  logic [31:0] cfgErrBits = 32'h0;
  logic [31:0] cfgMask = 32'hFFFF_FFFF;
  int cfgBusyPolls = 2;
  bit cfgHalf = 1'b0;
  bit cfgStuck = 1'b0;

  // device model state (driven by the model only)
  logic [31:0] mem [0:255];
  logic [31:0] wrDataLog [0:1023];
  logic [AW-1:0] wrAddrLog [0:1023];
  int wrCnt = 0;
  int statRd = 0;
  int arrRd = 0;
  int badCmd = 0;
  int mode = 0;      // 0 array, 1 identify, 2 status
  int pend = 0;      // 0 none, 1 erase setup seen, 2 program setup seen
  int pollsLeft = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
      mode = 0; pend = 0; pollsLeft = 0;
      flRdata <= '0;
    end else begin
      if (flRe) begin
        if (mode == 0) begin
          flRdata <= mem[flAddr];
          arrRd++;
        end else if (mode == 1) begin
          flRdata <= (flAddr == 0) ? cfgMfr : (flAddr == 1) ? cfgDev : 32'h0;
        end else begin
          statRd++;
          if (cfgStuck || pollsLeft > 0) begin
            if (pollsLeft > 0) pollsLeft--;
            flRdata <= cfgHalf ? 32'h0000_0080 : 32'h0;
          end else begin
            flRdata <= 32'h0080_0080 | cfgErrBits;
          end
        end
      end
      if (flWe) begin
        wrDataLog[wrCnt % 1024] = flWdata;
        wrAddrLog[wrCnt % 1024] = flAddr;
        wrCnt++;
        if (pend == 2) begin
          mem[flAddr] = flWdata & cfgMask;
          pend = 0; mode = 2; pollsLeft = cfgBusyPolls;
        end else if (flWdata[31:24] == 8'h0 && flWdata[15:8] == 8'h0 &&
                     flWdata[23:16] == flWdata[7:0]) begin
          case (flWdata[7:0])
            8'hFF: begin mode = 0; pend = 0; end
            8'h90: mode = 1;
            8'h70: mode = 2;
            8'h20: pend = 1;
            8'h40: pend = 2;
            8'hD0: begin
              if (pend == 1) begin
                for (int i = 0; i < 16; i++) mem[{flAddr[7:4], 4'(i)}] = 32'hFFFF_FFFF;
                mode = 2; pollsLeft = cfgBusyPolls;
              end else badCmd++;
              pend = 0;
            end
            default: badCmd++;
          endcase
        end else begin
          badCmd++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      $display("FAIL watchdog R10: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic setCfg();
    cfgMfr = 32'h0089_0089; cfgDev = 32'h88F3_88F3; cfgErrBits = 32'h0;
    cfgMask = 32'hFFFF_FFFF; cfgBusyPolls = 2; cfgHalf = 1'b0; cfgStuck = 1'b0;
  endtask

  task automatic runOp(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d,
                       output logic e);
    int n;
    @(negedge clk);
    reqOp = op; reqAddr = a; reqData = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy === 1'b1, "R10 busy after accept", {31'b0, busy}, 32'd1);
    n = 0;
    while (done !== 1'b1 && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, "R10 done reached", {31'b0, done}, 32'd1);
    e = err;
    @(negedge clk);
    chk(!done && !busy, "R10 done single pulse then idle", {30'b0, done, busy}, 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !flWe && !flRe, "R1 reset outputs",
        {27'b0, busy, done, err, flWe, flRe}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !flWe && !flRe, "R1 idle after release", {29'b0, busy, flWe, flRe}, 32'd0);
  endtask

  task automatic t_ident(input logic [31:0] m, input logic [31:0] dv, input logic expErr, input string tag);
    int b; logic e;
    setCfg(); cfgMfr = m; cfgDev = dv;
    b = wrCnt;
    runOp(2'd0, 8'h37, 32'h0, e);
    chk(e == expErr, {"R3 identify result ", tag}, {31'b0, e}, {31'b0, expErr});
    chk(wrCnt - b == 2 && wrDataLog[b] == 32'h0090_0090 && wrAddrLog[b] == 0 &&
        wrDataLog[b+1] == ARR_CMD && wrAddrLog[b+1] == 0,
        "R3 R2 identify write sequence", wrDataLog[b], 32'h0090_0090);
  endtask

  task automatic t_erase();
    int b, s; logic e;
    setCfg();
    runOp(2'd2, 8'h22, 32'h1111_2222, e);
    runOp(2'd2, 8'h30, 32'hA5A5_A5A5, e);
    b = wrCnt; s = statRd;
    runOp(2'd1, 8'h25, 32'h0, e);
    chk(e == 1'b0, "R4 erase ok", {31'b0, e}, 32'd0);
    chk(wrDataLog[b] == 32'h0020_0020 && wrAddrLog[b] == 8'h25 &&
        wrDataLog[b+1] == 32'h00D0_00D0 && wrAddrLog[b+1] == 8'h25,
        "R4 erase setup and confirm", wrDataLog[b+1], 32'h00D0_00D0);
    chk(mem[8'h22] == 32'hFFFF_FFFF, "R4 block erased", mem[8'h22], 32'hFFFF_FFFF);
    chk(mem[8'h30] == 32'hA5A5_A5A5, "R4 other block kept", mem[8'h30], 32'hA5A5_A5A5);
    chk(statRd - s == 3, "R6 poll count erase", statRd - s, 32'd3);
    chk(wrCnt - b == 6 && wrDataLog[b+5] == ARR_CMD && mode == 0,
        "R7 read array after erase", wrDataLog[b+5], ARR_CMD);
  endtask

  task automatic t_erase_err();
    logic e;
    setCfg(); cfgErrBits = 32'h0000_0020;
    runOp(2'd1, 8'h50, 32'h0, e);
    chk(e == 1'b1, "R7 erase error low half", {31'b0, e}, 32'd1);
    setCfg(); cfgErrBits = 32'h0010_0010;
    runOp(2'd1, 8'h50, 32'h0, e);
    chk(e == 1'b0, "R7 erase ignores program bit", {31'b0, e}, 32'd0);
  endtask

  task automatic t_prog();
    int b, a; logic e;
    setCfg();
    b = wrCnt; a = arrRd;
    runOp(2'd2, 8'h41, 32'h1234_5678, e);
    chk(e == 1'b0, "R5 program ok", {31'b0, e}, 32'd0);
    chk(wrDataLog[b] == 32'h0040_0040 && wrAddrLog[b] == 8'h41 &&
        wrDataLog[b+1] == 32'h1234_5678 && wrAddrLog[b+1] == 8'h41,
        "R5 program setup and data", wrDataLog[b+1], 32'h1234_5678);
    chk(mem[8'h41] == 32'h1234_5678, "R5 word stored", mem[8'h41], 32'h1234_5678);
    chk(arrRd - a == 1, "R8 one read-back", arrRd - a, 32'd1);
    setCfg(); cfgErrBits = 32'h0010_0000;
    runOp(2'd2, 8'h42, 32'h0000_0000, e);
    chk(e == 1'b1, "R7 program error high half", {31'b0, e}, 32'd1);
    setCfg(); cfgErrBits = 32'h0020_0020;
    runOp(2'd2, 8'h43, 32'h0000_0001, e);
    chk(e == 1'b0, "R7 program ignores erase bit", {31'b0, e}, 32'd0);
    setCfg(); cfgMask = 32'hFFFF_FFFE;
    runOp(2'd2, 8'h44, 32'h0000_0003, e);
    chk(e == 1'b1, "R8 verify mismatch", {31'b0, e}, 32'd1);
  endtask

  task automatic t_half();
    int s; logic e;
    setCfg(); cfgHalf = 1'b1; cfgBusyPolls = 3;
    s = statRd;
    runOp(2'd1, 8'h80, 32'h0, e);
    chk(statRd - s == 4, "R6 both halves needed", statRd - s, 32'd4);
    chk(e == 1'b0, "R6 ok after full ready", {31'b0, e}, 32'd0);
  endtask

  task automatic t_timeout();
    int b, s; logic e;
    setCfg(); cfgStuck = 1'b1;
    b = wrCnt; s = statRd;
    runOp(2'd1, 8'h90, 32'h0, e);
    chk(e == 1'b1, "R9 timeout error", {31'b0, e}, 32'd1);
    chk(statRd - s == MAXP, "R9 poll limit", statRd - s, MAXP);
    chk(wrCnt - b == MAXP + 3 && wrDataLog[b + MAXP + 2] == ARR_CMD,
        "R9 read array after timeout", wrDataLog[b + MAXP + 2], ARR_CMD);
  endtask

  task automatic t_ignore();
    int b, n, extra;
    setCfg(); cfgBusyPolls = 5;
    b = wrCnt;
    @(negedge clk);
    reqOp = 2'd1; reqAddr = 8'h65; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    reqOp = 2'd2; reqAddr = 8'h70; reqData = 32'h0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (done !== 1'b1 && n < 500) begin @(negedge clk); n++; end
    extra = 0;
    repeat (20) begin @(negedge clk); if (done) extra++; end
    chk(extra == 0 && mem[8'h70] == 32'hFFFF_FFFF, "R11 busy request ignored", extra, 32'd0);
    chk(wrCnt - b == 9, "R11 write count with ignored request", wrCnt - b, 32'd9);
    b = wrCnt; extra = 0;
    @(negedge clk);
    reqOp = 2'd3; reqAddr = 8'h71; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (10) begin @(negedge clk); if (busy || flRe) extra++; end
    chk(extra == 0 && wrCnt == b, "R11 op code 3 ignored", wrCnt - b + extra, 32'd0);
  endtask

  initial begin
    t_reset();
    t_ident(32'h0089_0089, 32'h88F3_88F3, 1'b0, "top");
    t_ident(32'h0089_0089, 32'h88F4_88F4, 1'b0, "bottom");
    t_ident(32'h0089_0089, 32'h88F1_88F1, 1'b1, "bad device");
    t_ident(32'h0089_0088, 32'h88F3_88F3, 1'b1, "bad maker");
    t_erase();
    t_erase_err();
    t_prog();
    t_half();
    t_timeout();
    t_ignore();
    chk(badCmd == 0, "R2 all commands well formed", badCmd, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule